// File: doc/BRIEF.md
# Lock-Gated Flash Control Register

This block is the control register of a nonvolatile memory controller. It holds the control bits that start and shape modify operations: erase request, half-page programming mode, parallel-bank mode, the error and end-of-operation interrupt enables, a switch that turns off the check for nonzero contents before programming, and a request to reload the option settings. Software reaches it through a simple register bus. Each bit has its own write permission, which depends on two lock inputs (a program/erase lock and an option lock) and on a busy status from the programming engine.

A bus write changes only the bits that may be written in that cycle. All other bits keep their value. Setting the program/erase lock clears the two bits that start work (erase request and half-page mode). The enables and the option-reload request survive any lock. While an option reload is pending, the block drives a blocked-start output so that the engine starts no new modify operation. An operation already running is left alone. Two parameters can remove the nonzero-check switch and the parallel-bank bit. A removed bit reads as 0 and acts as 0.

Top module: `flash_ctl_reg`

## Requirements
- R1: After a synchronous reset every implemented bit, every control output and the read data are 0.
- R2: The nonzero-check disable (bit 23), error interrupt enable (bit 17) and end-of-operation interrupt enable (bit 16) take a bus write only while pe_lock is 0. A high pe_lock never clears them.
- R3: Half-page mode (bit 10) and erase request (bit 9) take a bus write only while pe_lock is 0. At every clock edge where pe_lock is 1 they are forced to 0.
- R4: The option-reload request (bit 18) takes a bus write only while opt_lock is 0. Neither lock clears it.
- R5: Parallel-bank mode (bit 15) takes a bus write only while busy is 0, whatever the lock state.
- R6: Bits 31:24, 22:19, 14:11 and 8:0 read as 0, and writes to them have no effect.
- R7: A write acts only when bus_we is high and bus_addr equals REG_ADDR. bus_rdata shows the current register word in the same cycle that bus_re is high with a matching address. Otherwise bus_rdata is 0.
- R8: start_blocked is high exactly while the option-reload request bit is 1.
- R9: With HAS_NZ_BIT=0, bit 23 and nz_chk_off stay 0. With HAS_DUAL_BANK=0, bit 15 and dual_bank_en stay 0.
- R10: In a write where only some bits are permitted, the permitted bits take the new data and all other bits keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pe_lock | input | 1 | Program/erase lock |
| opt_lock | input | 1 | Option lock |
| busy | input | 1 | Program or erase operation in progress |
| erase_req | output | 1 | Erase request |
| half_page_en | output | 1 | Half-page programming mode |
| dual_bank_en | output | 1 | Parallel-bank programming mode |
| err_irq_en | output | 1 | Error interrupt enable |
| eop_irq_en | output | 1 | End-of-operation interrupt enable |
| nz_chk_off | output | 1 | Nonzero-check disable |
| opt_reload_req | output | 1 | Option reload request |
| start_blocked | output | 1 | New modify operations are blocked |

## Verification
Some rules hold on every cycle, and the assertions check these. A held lock or busy freezes the bits it guards. The program/erase lock forces the start bits to 0. Reserved bits read as 0. An idle bus reads as 0. start_blocked follows the reload request. Other behaviour needs a chosen sequence of stimulus, and only the bench scenarios can show it. Such cases are a write that succeeds after unlock, a mixed write where some fields land and others do not, a write to a wrong address, and the reduced parameter set. The reference model in the bench checks all of these on every clock.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int NB = 7;
  // field index order inside the register file
  localparam int F_ERASE  = 0;
  localparam int F_HALF   = 1;
  localparam int F_BANK   = 2;
  localparam int F_EOPIE  = 3;
  localparam int F_ERRIE  = 4;
  localparam int F_RELOAD = 5;
  localparam int F_NZOFF  = 6;

  function automatic int bit_pos(input int f);
    case (f)
      F_ERASE:  bit_pos = 9;
      F_HALF:   bit_pos = 10;
      F_BANK:   bit_pos = 15;
      F_EOPIE:  bit_pos = 16;
      F_ERRIE:  bit_pos = 17;
      F_RELOAD: bit_pos = 18;
      default:  bit_pos = 23;
    endcase
  endfunction

  localparam logic [31:0] USED_MASK = 32'h0087_8600;
endpackage

// File: rtl/fcr_perm.sv
module fcr_perm
  import fcr_pkg::*;
(
  input  logic          wr_hit,
  input  logic          pe_lock,
  input  logic          opt_lock,
  input  logic          busy,
  output logic [NB-1:0] we_v,
  output logic [NB-1:0] clr_v
);
  always_comb begin
    we_v  = '0;
    clr_v = '0;
    we_v[F_ERASE]  = wr_hit && !pe_lock;
    we_v[F_HALF]   = wr_hit && !pe_lock;
    we_v[F_BANK]   = wr_hit && !busy;
    we_v[F_EOPIE]  = wr_hit && !pe_lock;
    we_v[F_ERRIE]  = wr_hit && !pe_lock;
    we_v[F_RELOAD] = wr_hit && !opt_lock;
    we_v[F_NZOFF]  = wr_hit && !pe_lock;
    clr_v[F_ERASE] = pe_lock;
    clr_v[F_HALF]  = pe_lock;
  end
endmodule

// File: rtl/fcr_cell.sv
module fcr_cell #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic clr,
  input  logic d,
  output logic q
);
  generate
    if (IMPL) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (we)  q <= d;
      end
    end else begin : g_absent
      wire unused_ok = &{1'b0, clk, rst, we, clr, d};
      assign q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fcr_readback.sv
module fcr_readback
  import fcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NB-1:0]     q,
  input  logic              sel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word;
  always_comb begin
    word = '0;
    for (int f = 0; f < NB; f++) word[bit_pos(f)] = q[f];
  end
  assign rdata = sel ? word : '0;
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import fcr_pkg::*;
#(
  parameter int          ADDR_W        = 4,
  parameter int          DATA_W        = 32,
  parameter logic [3:0]  REG_ADDR      = 4'h0,
  parameter bit          HAS_NZ_BIT    = 1'b1,
  parameter bit          HAS_DUAL_BANK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pe_lock,
  input  logic              opt_lock,
  input  logic              busy,
  output logic              erase_req,
  output logic              half_page_en,
  output logic              dual_bank_en,
  output logic              err_irq_en,
  output logic              eop_irq_en,
  output logic              nz_chk_off,
  output logic              opt_reload_req,
  output logic              start_blocked
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic          addr_hit, wr_hit, rd_sel;
  logic [NB-1:0] we_v, clr_v, q_v;

  assign addr_hit = (bus_addr == MY_ADDR);
  assign wr_hit   = bus_we && addr_hit;
  assign rd_sel   = bus_re && addr_hit;

  fcr_perm u_perm (
    .wr_hit(wr_hit), .pe_lock(pe_lock), .opt_lock(opt_lock), .busy(busy),
    .we_v(we_v), .clr_v(clr_v)
  );

  genvar f;
  generate
    for (f = 0; f < NB; f++) begin : g_field
      localparam bit PRESENT = (f == F_NZOFF) ? HAS_NZ_BIT :
                               (f == F_BANK)  ? HAS_DUAL_BANK : 1'b1;
      fcr_cell #(.IMPL(PRESENT)) u_cell (
        .clk(clk), .rst(rst), .we(we_v[f]), .clr(clr_v[f]),
        .d(bus_wdata[bit_pos(f)]), .q(q_v[f])
      );
    end
  endgenerate

  // separate flag that the engine samples to hold off new operations
  always_ff @(posedge clk) begin
    if (rst)                 start_blocked <= 1'b0;
    else if (we_v[F_RELOAD]) start_blocked <= bus_wdata[bit_pos(F_RELOAD)];
  end

  fcr_readback #(.DATA_W(DATA_W)) u_rb (
    .q(q_v), .sel(rd_sel), .rdata(bus_rdata)
  );

  assign erase_req      = q_v[F_ERASE];
  assign half_page_en   = q_v[F_HALF];
  assign dual_bank_en   = q_v[F_BANK];
  assign eop_irq_en     = q_v[F_EOPIE];
  assign err_irq_en     = q_v[F_ERRIE];
  assign opt_reload_req = q_v[F_RELOAD];
  assign nz_chk_off     = q_v[F_NZOFF];

  wire unused_wdata = &{1'b0, bus_wdata & ~DATA_W'(USED_MASK)};
endmodule

// File: rtl/fcr_checker.sv
module fcr_checker (
  input logic        clk,
  input logic        rst,
  input logic        bus_re,
  input logic [31:0] bus_rdata,
  input logic        pe_lock,
  input logic        opt_lock,
  input logic        busy,
  input logic        erase_req,
  input logic        half_page_en,
  input logic        dual_bank_en,
  input logic        err_irq_en,
  input logic        eop_irq_en,
  input logic        nz_chk_off,
  input logic        opt_reload_req,
  input logic        start_blocked
);
  AST_PE_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    pe_lock |=> $stable({nz_chk_off, err_irq_en, eop_irq_en})); // R2
  AST_LOCK_CLEARS_START: assert property (@(posedge clk) disable iff (rst)
    pe_lock |=> (!erase_req && !half_page_en)); // R3
  AST_OPT_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    opt_lock |=> $stable(opt_reload_req)); // R4
  AST_BUSY_FREEZE_BANK: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dual_bank_en)); // R5
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~32'h0087_8600) == 32'h0); // R6
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_re |-> (bus_rdata == 32'h0)); // R7
  AST_BLOCK_TRACKS_RELOAD: assert property (@(posedge clk) disable iff (rst)
    start_blocked == opt_reload_req); // R8
endmodule

bind flash_ctl_reg fcr_checker u_fcr_chk (.*);

// File: tb/test_flash_ctl_reg.sv
module test_flash_ctl_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic        pe_lock = 1'b1, opt_lock = 1'b1, busy = 1'b0;
  logic [31:0] rdata, rdata_l;
  logic erase_req, half_page_en, dual_bank_en, err_irq_en, eop_irq_en;
  logic nz_chk_off, opt_reload_req, start_blocked;
  logic erase_l, half_l, bank_l, err_l, eop_l, nz_l, reload_l, blk_l;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit run_model_checks = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  flash_ctl_reg i_flash_ctl_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .pe_lock(pe_lock), .opt_lock(opt_lock),
    .busy(busy), .erase_req(erase_req), .half_page_en(half_page_en),
    .dual_bank_en(dual_bank_en), .err_irq_en(err_irq_en), .eop_irq_en(eop_irq_en),
    .nz_chk_off(nz_chk_off), .opt_reload_req(opt_reload_req), .start_blocked(start_blocked)
  );

  flash_ctl_reg #(.HAS_NZ_BIT(1'b0), .HAS_DUAL_BANK(1'b0)) i_flash_ctl_reg_lite (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .pe_lock(pe_lock), .opt_lock(opt_lock),
    .busy(busy), .erase_req(erase_l), .half_page_en(half_l),
    .dual_bank_en(bank_l), .err_irq_en(err_l), .eop_irq_en(eop_l),
    .nz_chk_off(nz_l), .opt_reload_req(reload_l), .start_blocked(blk_l)
  );

  // behavioural reference: one 32-bit word, bit positions from the requirements
  logic [31:0] m;
  always @(posedge clk) begin
    if (rst) m = 32'h0;
    else begin
      if (bus_we && bus_addr == 4'h0) begin
        if (!pe_lock) begin
          m[23] = bus_wdata[23]; m[17] = bus_wdata[17]; m[16] = bus_wdata[16];
          m[10] = bus_wdata[10]; m[9]  = bus_wdata[9];
        end
        if (!opt_lock) m[18] = bus_wdata[18];
        if (!busy)     m[15] = bus_wdata[15];
      end
      if (pe_lock) begin m[10] = 1'b0; m[9] = 1'b0; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd_exp(input logic [31:0] w);
    return (bus_re && bus_addr == 4'h0) ? w : 32'h0;
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (run_model_checks) begin
      chk("R2 R3 R4 R5 outputs",
          {25'h0, nz_chk_off, opt_reload_req, err_irq_en, eop_irq_en, dual_bank_en, half_page_en, erase_req},
          {25'h0, m[23], m[18], m[17], m[16], m[15], m[10], m[9]});
      chk("R7 readback", rdata, rd_exp(m));
      chk("R8 start_blocked", {31'h0, start_blocked}, {31'h0, m[18]});
      chk("R9 reduced readback", rdata_l, rd_exp(m & ~32'h0080_8000));
      chk("R9 reduced outputs", {30'h0, nz_l, bank_l}, 32'h0);
    end
  end

  task automatic step(input logic we, input logic re, input logic [3:0] a, input logic [31:0] d);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    #2;
    // R1: reset state, read strobe on
    bus_re = 1'b1; #0.5;
    chk("R1 reset readback", rdata, 32'h0);
    chk("R1 reset outputs", {24'h0, erase_req, half_page_en, dual_bank_en, err_irq_en,
        eop_irq_en, nz_chk_off, opt_reload_req, start_blocked}, 32'h0);
    @(posedge clk); #2;
    run_model_checks = 1'b1;
    // both locks set: only bank takes the write (R10 partial write)
    step(1, 0, 4'h0, 32'hFFFF_FFFF);
    step(0, 1, 4'h0, 32'h0); #2;
    chk("R10 locked write keeps others", rdata, 32'h0000_8000);
    #2;
    // unlock program/erase, write all ones; reload stays (opt locked)
    pe_lock = 1'b0;
    step(1, 0, 4'h0, 32'hFFFF_FFFF);
    step(0, 1, 4'h0, 32'h0); #2;
    chk("R6 reserved bits zero", rdata & ~32'h0087_8600, 32'h0);
    chk("R2 enables set", rdata, 32'h0083_8600);
    #2;
    // wrong address write ignored
    step(1, 0, 4'h3, 32'h0);
    step(0, 1, 4'h3, 32'h0); #2;
    chk("R7 other address reads zero", rdata, 32'h0);
    #2;
    // relock: start bits clear, enables stay
    pe_lock = 1'b1;
    step(0, 0, 4'h0, 32'h0);
    step(0, 1, 4'h0, 32'h0); #2;
    chk("R3 lock clears start bits", rdata, 32'h0083_8000);
    #2;
    // option unlock, set reload
    opt_lock = 1'b0;
    step(1, 0, 4'h0, 32'h0004_0000);
    opt_lock = 1'b1;
    step(0, 0, 4'h0, 32'h0); #2;
    chk("R8 blocked while pending", {31'h0, start_blocked}, 32'h1);
    #2;
    // locked: clear attempt ignored for reload and pe bits, bank clears
    step(1, 0, 4'h0, 32'h0);
    step(0, 1, 4'h0, 32'h0); #2;
    chk("R4 reload survives locks", rdata, 32'h0087_0000 & 32'h0087_0000);
    #2;
    // busy: bank write ignored
    busy = 1'b1;
    step(1, 0, 4'h0, 32'h0000_8000);
    step(0, 1, 4'h0, 32'h0); #2;
    chk("R5 busy blocks bank", rdata[15] ? 32'h1 : 32'h0, 32'h0);
    #2;
    busy = 1'b0;
    step(1, 0, 4'h0, 32'h0000_8000);
    step(0, 1, 4'h0, 32'h0);
    // unlock everything, clear all, mixed busy write
    pe_lock = 1'b0; opt_lock = 1'b0; busy = 1'b1;
    step(1, 0, 4'h0, 32'h0000_0600);
    step(0, 1, 4'h0, 32'h0); #2;
    chk("R10 mixed write", rdata, 32'h0000_8600);
    #2;
    busy = 1'b0;
    step(1, 1, 4'h0, 32'h0);
    step(0, 1, 4'h0, 32'h0);
    repeat (4) step(0, 0, 4'h0, 32'h0);
    run_model_checks = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule